// File: doc/BRIEF.md
# I2C Target with Command Mailbox

This block is an I2C bus target that answers at 7-bit address 0x49. Its write address byte is 0x92 and its read address byte is 0x93. It serves three kinds of transfer:

- **Register read.** The controller writes one pointer byte, issues a repeated START, and reads bytes that come from an external register file. The address auto-increments on each byte.
- **Command write.** The controller writes an operation code, an input length `m` and `m` input bytes. When STOP ends the transfer, the block issues an execute strobe.
- **Response read.** The controller writes a pointer byte equal to the code of the loaded response, issues a repeated START, and reads back the code, the response length and the response bytes.

SCL and SDA are sampled with the system clock through two-flop synchronizers. The system clock must run at least 8 times the SCL rate. START and STOP are found as SDA edges while SCL is high. SDA is open drain: `sda_oe` high pulls the line low.

There is no back-pressure on the command output. `cmd_valid` is a one-cycle strobe with no ready, so a consumer must take `cmd_api`, `cmd_len` and `cmd_data` in that cycle. The response side is loaded by a one-cycle `rsp_load` strobe with no ready, and it is accepted in every cycle. The register file is read combinationally through `reg_addr` and `reg_rdata`.

A pointer byte selects the response only when a response has been loaded and the byte equals the loaded code. Any other pointer byte selects the register file.

Top module: `i2c_mailbox_target`

## Requirements
- R1: The block ACKs address byte 0x92 (write) and 0x93 (read). Any other address byte gets no ACK, and SDA stays released until the next START.
- R2: Every byte the controller writes to the matched address is ACKed, within the input capacity.
- R3: A register read returns register p, p+1, p+2, and so on, where p is the pointer byte of the preceding write. Each byte is sent MSB first.
- R4: A read at a register index of NUM_REGS (32) or above returns 0xFF.
- R5: After the controller NACKs a read byte, SDA is released and stays released until the next START. STOP always releases SDA.
- R6: A command write carries, in order, the code byte, the length byte m and m input bytes. `cmd_valid` pulses only after STOP, with `cmd_api`, `cmd_len` and the input bytes in `cmd_data` (byte j at bits 8j+7:8j).
- R7: A command with m = 0 (two bytes, then STOP) executes.
- R8: If STOP arrives with a number of input bytes different from m, there is no execute strobe and `cmd_err` pulses for one cycle.
- R9: The input buffer holds 16 bytes. A 17th input byte is NACKed, and the command ends in `cmd_err` with no strobe.
- R10: A response read returns the loaded code, then the length n, then n response bytes. Every further byte is 0xFF.
- R11: The block changes SDA only after an SCL falling edge, except for the release at STOP.
- R12: A repeated START after command bytes discards the command, with neither strobe nor error.
- R13: A write of only a pointer byte followed by STOP produces neither strobe nor error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line state |
| sda_i | input | 1 | SDA line state |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | 8 | Register file read address |
| reg_rdata | input | 8 | Register file read data (combinational) |
| cmd_valid | output | 1 | Execute strobe, one cycle |
| cmd_err | output | 1 | Malformed command, one cycle |
| cmd_api | output | 8 | Command code, valid with strobe |
| cmd_len | output | 8 | Input length, valid with strobe |
| cmd_data | output | 128 | Input bytes, valid with strobe |
| rsp_load | input | 1 | Load response fields |
| rsp_api | input | 8 | Response code |
| rsp_len | input | 8 | Response length |
| rsp_data | input | 128 | Response bytes, byte k at 8k+7:8k |

## Verification
The following properties are checked in every cycle:

- SDA changes only after an SCL fall, or at STOP or START.
- SDA is released after a controller NACK and at STOP.
- A foreign address is never ACKed.
- The input count never exceeds its capacity.
- An execute strobe never appears without a STOP in the previous cycle.
- An execute strobe never coincides with an error, and never follows a length mismatch.

Only the bench scenarios can show the data-level behaviour:

- the byte values of auto-incrementing register and response reads, and 0xFF past their ends;
- the captured command fields;
- the NACK of the 17th input byte;
- the silent discard on repeated START and on a pointer-only write.

// File: rtl/i2c_mb_pkg.sv
package i2c_mb_pkg;
  localparam logic [6:0] DEF_DEV_ADDR = 7'h49;
  localparam int         BYTE_W       = 8;

  typedef enum logic [2:0] {
    L_IDLE, L_RX, L_RXDONE, L_ACK, L_TX, L_RACK, L_RACKW, L_WAIT
  } link_st_e;
endpackage

// File: rtl/i2c_mb_sync.sv
module i2c_mb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      prev <= 1'b1;
    end else begin
      sr   <= {sr[STAGES-2:0], d};
      prev <= sr[STAGES-1];
    end
  end

  assign q    = sr[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/i2c_mb_link.sv
module i2c_mb_link
  import i2c_mb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              wr_nack,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              ev_start,
  output logic              ev_stop,
  output logic              ev_addr,
  output logic              rw,
  output logic              ev_wr,
  output logic [BYTE_W-1:0] ev_byte,
  output logic              ev_rd_adv
);
  link_st_e          st;
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              is_addr;
  logic              start_det;
  logic              stop_det;

  assign start_det = sda_fall & scl_s;
  assign stop_det  = sda_rise & scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= L_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      is_addr   <= 1'b0;
      rw        <= 1'b0;
      sda_oe    <= 1'b0;
      ev_start  <= 1'b0;
      ev_stop   <= 1'b0;
      ev_addr   <= 1'b0;
      ev_wr     <= 1'b0;
      ev_byte   <= '0;
      ev_rd_adv <= 1'b0;
    end else begin
      ev_start  <= 1'b0;
      ev_stop   <= 1'b0;
      ev_addr   <= 1'b0;
      ev_wr     <= 1'b0;
      ev_rd_adv <= 1'b0;
      if (start_det) begin
        st       <= L_RX;
        cnt      <= '0;
        is_addr  <= 1'b1;
        sda_oe   <= 1'b0;
        ev_start <= 1'b1;
      end else if (stop_det) begin
        st      <= L_IDLE;
        sda_oe  <= 1'b0;
        ev_stop <= 1'b1;
      end else begin
        case (st)
          L_RX: if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              st <= L_RXDONE;
              if (!is_addr) begin
                ev_wr   <= 1'b1;
                ev_byte <= {sh[BYTE_W-2:0], sda_s};
              end
            end
          end
          L_RXDONE: if (scl_fall) begin
            if (is_addr) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe  <= 1'b1;
                rw      <= sh[0];
                ev_addr <= 1'b1;
                st      <= L_ACK;
              end else begin
                st <= L_WAIT;
              end
            end else if (wr_nack) begin
              st <= L_WAIT;
            end else begin
              sda_oe <= 1'b1;
              st     <= L_ACK;
            end
          end
          L_ACK: if (scl_fall) begin
            is_addr <= 1'b0;
            cnt     <= '0;
            if (rw) begin
              tx        <= tx_byte;
              sda_oe    <= ~tx_byte[7];
              ev_rd_adv <= 1'b1;
              st        <= L_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= L_RX;
            end
          end
          L_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= L_RACK;
            end else begin
              cnt    <= cnt + 3'd1;
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
          L_RACK: if (scl_rise) st <= sda_s ? L_WAIT : L_RACKW;
          L_RACKW: if (scl_fall) begin
            cnt       <= '0;
            tx        <= tx_byte;
            sda_oe    <= ~tx_byte[7];
            ev_rd_adv <= 1'b1;
            st        <= L_TX;
          end
          default: ;
        endcase
      end
    end
  end

  AST_RELEASE_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == L_RACK && scl_rise && sda_s && !start_det && !stop_det) |=> (!sda_oe && st == L_WAIT)); // R5
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R5
  AST_SDA_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(stop_det) || $past(start_det))); // R11
  AST_NO_FOREIGN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == L_RXDONE && is_addr && scl_fall && !start_det && !stop_det && sh[7:1] != DEV_ADDR)
      |=> (!sda_oe && st == L_WAIT)); // R1
endmodule

// File: rtl/i2c_mb_frame.sv
module i2c_mb_frame
  import i2c_mb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int CMD_DEPTH = 16,
  parameter int RSP_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_start,
  input  logic                        ev_stop,
  input  logic                        ev_addr,
  input  logic                        rw,
  input  logic                        ev_wr,
  input  logic [BYTE_W-1:0]           ev_byte,
  input  logic                        ev_rd_adv,
  output logic                        wr_nack,
  output logic [BYTE_W-1:0]           tx_byte,
  output logic [BYTE_W-1:0]           reg_addr,
  input  logic [BYTE_W-1:0]           reg_rdata,
  output logic                        cmd_valid,
  output logic                        cmd_err,
  output logic [BYTE_W-1:0]           cmd_api,
  output logic [BYTE_W-1:0]           cmd_len,
  output logic [CMD_DEPTH*BYTE_W-1:0] cmd_data,
  input  logic                        rsp_load,
  input  logic [BYTE_W-1:0]           rsp_api,
  input  logic [BYTE_W-1:0]           rsp_len,
  input  logic [RSP_DEPTH*BYTE_W-1:0] rsp_data
);
  localparam int            CW    = $clog2(CMD_DEPTH + 1);
  localparam int            IW    = $clog2(CMD_DEPTH);
  localparam int            RIW   = $clog2(RSP_DEPTH);
  localparam logic [CW-1:0] CMAX  = CW'(CMD_DEPTH);
  localparam logic [8:0]    RMAX  = 9'(RSP_DEPTH);
  localparam logic [8:0]    NREG9 = 9'(NUM_REGS);

  logic [BYTE_W-1:0] cbuf [CMD_DEPTH];
  logic [BYTE_W-1:0] rbuf [RSP_DEPTH];
  logic [BYTE_W-1:0] ptr, api_q, len_q, rapi_q, rlen_q;
  logic [1:0]        wr_cnt;
  logic [CW-1:0]     in_cnt;
  logic              wr_act, ovf, rsp_ok, rd_rsp;
  logic [8:0]        rd_idx, reg_ptr, rk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      api_q     <= '0;
      len_q     <= '0;
      rapi_q    <= '0;
      rlen_q    <= '0;
      wr_cnt    <= '0;
      in_cnt    <= '0;
      wr_act    <= 1'b0;
      ovf       <= 1'b0;
      rsp_ok    <= 1'b0;
      rd_rsp    <= 1'b0;
      rd_idx    <= '0;
      reg_ptr   <= '0;
      wr_nack   <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_err   <= 1'b0;
      for (int i = 0; i < CMD_DEPTH; i++) cbuf[i] <= '0;
      for (int i = 0; i < RSP_DEPTH; i++) rbuf[i] <= '0;
    end else begin
      cmd_valid <= 1'b0;
      cmd_err   <= 1'b0;
      if (rsp_load) begin
        rapi_q <= rsp_api;
        rlen_q <= rsp_len;
        rsp_ok <= 1'b1;
        for (int i = 0; i < RSP_DEPTH; i++) rbuf[i] <= rsp_data[i*BYTE_W +: BYTE_W];
      end
      if (ev_start) wr_act <= 1'b0;
      if (ev_stop) begin
        wr_act <= 1'b0;
        if (wr_act && wr_cnt == 2'd2) begin
          if (!ovf && BYTE_W'(in_cnt) == len_q) cmd_valid <= 1'b1;
          else                                  cmd_err   <= 1'b1;
        end
      end
      if (ev_addr) begin
        if (!rw) begin
          wr_act  <= 1'b1;
          wr_cnt  <= '0;
          in_cnt  <= '0;
          ovf     <= 1'b0;
          wr_nack <= 1'b0;
        end else begin
          rd_rsp  <= rsp_ok && (ptr == rapi_q);
          rd_idx  <= '0;
          reg_ptr <= {1'b0, ptr};
        end
      end
      if (ev_wr) begin
        case (wr_cnt)
          2'd0: begin
            ptr    <= ev_byte;
            api_q  <= ev_byte;
            wr_cnt <= 2'd1;
          end
          2'd1: begin
            len_q  <= ev_byte;
            wr_cnt <= 2'd2;
          end
          default: begin
            if (in_cnt < CMAX) begin
              cbuf[in_cnt[IW-1:0]] <= ev_byte;
              in_cnt  <= in_cnt + 1'b1;
              wr_nack <= 1'b0;
            end else begin
              ovf     <= 1'b1;
              wr_nack <= 1'b1;
            end
          end
        endcase
      end
      if (ev_rd_adv) begin
        if (rd_idx != 9'h1FF) rd_idx <= rd_idx + 9'd1;
        if (!reg_ptr[8])      reg_ptr <= reg_ptr + 9'd1;
      end
    end
  end

  assign rk       = rd_idx - 9'd2;
  assign reg_addr = reg_ptr[7:0];

  always_comb begin
    if (rd_rsp) begin
      if (rd_idx == 9'd0)                                   tx_byte = rapi_q;
      else if (rd_idx == 9'd1)                              tx_byte = rlen_q;
      else if (rk < {1'b0, rlen_q} && rk < RMAX)            tx_byte = rbuf[rk[RIW-1:0]];
      else                                                  tx_byte = 8'hFF;
    end else begin
      tx_byte = (reg_ptr < NREG9) ? reg_rdata : 8'hFF;
    end
  end

  assign cmd_api = api_q;
  assign cmd_len = len_q;
  for (genvar g = 0; g < CMD_DEPTH; g++) begin : g_out
    assign cmd_data[g*BYTE_W +: BYTE_W] = cbuf[g];
  end

  AST_EXEC_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(ev_stop)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= CMAX); // R9
  AST_EXEC_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_err)); // R8
  AST_SHORT_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_stop) && BYTE_W'($past(in_cnt)) != $past(len_q)) |-> !cmd_valid); // R8
endmodule

// File: rtl/i2c_mailbox_target.sv
module i2c_mailbox_target
  import i2c_mb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = DEF_DEV_ADDR,
  parameter int         NUM_REGS  = 32,
  parameter int         CMD_DEPTH = 16,
  parameter int         RSP_DEPTH = 16,
  parameter int         SYNC_LEN  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe,
  output logic [7:0]                  reg_addr,
  input  logic [7:0]                  reg_rdata,
  output logic                        cmd_valid,
  output logic                        cmd_err,
  output logic [7:0]                  cmd_api,
  output logic [7:0]                  cmd_len,
  output logic [CMD_DEPTH*8-1:0]      cmd_data,
  input  logic                        rsp_load,
  input  logic [7:0]                  rsp_api,
  input  logic [7:0]                  rsp_len,
  input  logic [RSP_DEPTH*8-1:0]      rsp_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in, line_q, line_r, line_f;
  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_mb_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (line_in[g]),
      .q (line_q[g]), .rise (line_r[g]), .fall (line_f[g])
    );
  end

  logic       ev_start, ev_stop, ev_addr, rw, ev_wr, ev_rd_adv, wr_nack;
  logic [7:0] ev_byte, tx_byte;

  i2c_mb_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk (clk), .rst_n (rst_n),
    .scl_s (line_q[1]), .scl_rise (line_r[1]), .scl_fall (line_f[1]),
    .sda_s (line_q[0]), .sda_rise (line_r[0]), .sda_fall (line_f[0]),
    .wr_nack (wr_nack), .tx_byte (tx_byte), .sda_oe (sda_oe),
    .ev_start (ev_start), .ev_stop (ev_stop), .ev_addr (ev_addr), .rw (rw),
    .ev_wr (ev_wr), .ev_byte (ev_byte), .ev_rd_adv (ev_rd_adv)
  );

  i2c_mb_frame #(.NUM_REGS(NUM_REGS), .CMD_DEPTH(CMD_DEPTH), .RSP_DEPTH(RSP_DEPTH)) u_frame (
    .clk (clk), .rst_n (rst_n),
    .ev_start (ev_start), .ev_stop (ev_stop), .ev_addr (ev_addr), .rw (rw),
    .ev_wr (ev_wr), .ev_byte (ev_byte), .ev_rd_adv (ev_rd_adv),
    .wr_nack (wr_nack), .tx_byte (tx_byte),
    .reg_addr (reg_addr), .reg_rdata (reg_rdata),
    .cmd_valid (cmd_valid), .cmd_err (cmd_err), .cmd_api (cmd_api),
    .cmd_len (cmd_len), .cmd_data (cmd_data),
    .rsp_load (rsp_load), .rsp_api (rsp_api), .rsp_len (rsp_len), .rsp_data (rsp_data)
  );
endmodule

// File: tb/i2c_mailbox_target_tb.sv
module i2c_mailbox_target_tb;
  localparam int Q     = 15;
  localparam int NREGS = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl_m = 1'b1, sda_m = 1'b1;
  logic         sda_oe;
  logic [7:0]   reg_addr, reg_rdata;
  logic         cmd_valid, cmd_err;
  logic [7:0]   cmd_api, cmd_len;
  logic [127:0] cmd_data;
  logic         rsp_load = 1'b0;
  logic [7:0]   rsp_api = '0, rsp_len = '0;
  logic [127:0] rsp_data = '0;
  wire          sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_mailbox_target u_dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line), .sda_oe (sda_oe),
    .reg_addr (reg_addr), .reg_rdata (reg_rdata),
    .cmd_valid (cmd_valid), .cmd_err (cmd_err), .cmd_api (cmd_api), .cmd_len (cmd_len),
    .cmd_data (cmd_data), .rsp_load (rsp_load), .rsp_api (rsp_api), .rsp_len (rsp_len),
    .rsp_data (rsp_data)
  );

  function automatic logic [7:0] reg_model(input logic [7:0] a);
    return (a * 8'd13) ^ 8'h5A;
  endfunction
  assign reg_rdata = reg_model(reg_addr);

  int total = 0, bad = 0, n_exec = 0, n_err = 0, exp_exec = 0, exp_err = 0;
  logic [7:0]   last_api, last_len;
  logic [127:0] last_data;
  logic [7:0]   wdata [20];
  bit           done = 0;

  always @(posedge clk) begin
    if (cmd_valid) begin
      n_exec++;
      last_api  = cmd_api;
      last_len  = cmd_len;
      last_data = cmd_data;
    end
    if (cmd_err) n_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s1;
    bit   steady = 1;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      s1 = sda_line; b = {b[6:0], s1};
      wq();
      if (sda_line != s1) steady = 0;
      scl_m = 1'b0; wq();
    end
    chk(steady, "R11 sda steady while scl high", steady, 1);
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic reg_read(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] b, e;
    int idx;
    i2c_start();
    send_byte(8'h92, a); chk(a, "R1 write address ack", a, 1);
    send_byte(p, a);     chk(a, "R2 pointer ack", a, 1);
    i2c_start();
    send_byte(8'h93, a); chk(a, "R1 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      idx = int'(p) + i;
      e = (idx < NREGS) ? reg_model(8'(idx)) : 8'hFF;
      chk(b == e, (idx < NREGS) ? "R3 register byte" : "R4 past last register", b, e);
    end
    chk(!sda_oe, "R5 released after nack", sda_oe, 0);
    i2c_stop();
    chk(!sda_oe, "R5 released after stop", sda_oe, 0);
  endtask

  task automatic cmd_write(input logic [7:0] api, input int m, input int k);
    logic a;
    int   sent = 0;
    bit   good;
    i2c_start();
    send_byte(8'h92, a); chk(a, "R1 write address ack", a, 1);
    send_byte(api, a);   chk(a, "R2 code byte ack", a, 1);
    send_byte(8'(m), a); chk(a, "R2 length byte ack", a, 1);
    for (int j = 0; j < k; j++) begin
      wdata[j] = 8'($urandom);
      send_byte(wdata[j], a);
      sent++;
      if (j < 16) chk(a, "R2 input byte ack", a, 1);
      else        chk(!a, "R9 byte past capacity nacked", a, 0);
      if (!a) break;
    end
    repeat (20) @(negedge clk);
    chk(n_exec == exp_exec, "R6 no strobe before stop", n_exec, exp_exec);
    i2c_stop();
    repeat (10) @(negedge clk);
    good = (sent == m) && (sent <= 16);
    if (good) exp_exec++; else exp_err++;
    chk(n_exec == exp_exec, good ? ((m == 0) ? "R7 zero-length exec" : "R6 exec on stop")
                                 : "R8 no exec on bad length", n_exec, exp_exec);
    chk(n_err == exp_err, good ? "R6 no error" : ((sent > 16) ? "R9 overflow error" : "R8 error flag"),
        n_err, exp_err);
    if (good) begin
      chk(last_api == api, "R6 code field", last_api, api);
      chk(last_len == 8'(m), "R6 length field", last_len, m);
      for (int j = 0; j < m; j++)
        chk(last_data[j*8 +: 8] == wdata[j], "R6 input byte", last_data[j*8 +: 8], wdata[j]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sda_oe && !cmd_valid && !cmd_err, "R1 reset state", {sda_oe, cmd_valid, cmd_err}, 0);

    // R1 foreign address
    i2c_start();
    send_byte(8'h52, a);
    chk(!a && !sda_oe, "R1 foreign address ignored", a, 0);
    send_byte(8'h00, a);
    chk(!a, "R1 bus stays released", a, 0);
    i2c_stop();

    reg_read(8'd3, 4);
    reg_read(8'(NREGS - 2), 4);

    cmd_write(8'h21, 3, 3);
    cmd_write(8'h22, 0, 0);
    cmd_write(8'h23, 5, 2);
    cmd_write(8'h24, 1, 2);
    cmd_write(8'h25, 20, 17);
    cmd_write(8'h26, 16, 16);

    // R12 repeated start discards command
    i2c_start();
    send_byte(8'h92, a); send_byte(8'h30, a); send_byte(8'h02, a);
    send_byte(8'h11, a); send_byte(8'h22, a);
    i2c_start();
    send_byte(8'h93, a); chk(a, "R12 read address ack", a, 1);
    recv_byte(0, b);
    chk(b == 8'hFF, "R12 pointer 0x30 reads past registers", b, 8'hFF);
    i2c_stop();
    repeat (10) @(negedge clk);
    chk(n_exec == exp_exec && n_err == exp_err, "R12 no strobe no error", n_exec + n_err, exp_exec + exp_err);

    // R13 pointer-only write
    i2c_start();
    send_byte(8'h92, a); send_byte(8'h05, a);
    i2c_stop();
    repeat (10) @(negedge clk);
    chk(n_exec == exp_exec && n_err == exp_err, "R13 pointer-only write silent", n_exec + n_err, exp_exec + exp_err);

    // R10 response read
    rsp_api = 8'h77; rsp_len = 8'd3;
    for (int k = 0; k < 16; k++) rsp_data[k*8 +: 8] = 8'hC0 + 8'(k);
    rsp_load = 1'b1; @(negedge clk); rsp_load = 1'b0;
    i2c_start();
    send_byte(8'h92, a); send_byte(8'h77, a);
    i2c_start();
    send_byte(8'h93, a); chk(a, "R10 read address ack", a, 1);
    for (int i = 0; i < 7; i++) begin
      logic [7:0] e;
      recv_byte(i < 6, b);
      if (i == 0)      e = 8'h77;
      else if (i == 1) e = 8'd3;
      else if (i < 5)  e = 8'hC0 + 8'(i - 2);
      else             e = 8'hFF;
      chk(b == e, "R10 response byte", b, e);
    end
    chk(!sda_oe, "R5 released after response nack", sda_oe, 0);
    i2c_stop();

    // random mix
    for (int t = 0; t < 5; t++) begin
      int m, k;
      reg_read(8'($urandom_range(0, 40)), $urandom_range(1, 4));
      m = $urandom_range(0, 5);
      k = ($urandom_range(0, 3) == 0 && m > 0) ? m - 1 : m;
      cmd_write(8'($urandom_range(1, 200)), m, k);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule